// File: doc/BRIEF.md
# Pipelined chunked ripple-carry adder

This block adds two W-bit operands and a carry-in. It is fully pipelined and accepts a new operand pair on every clock. Both operands are cut into ceil(W/M) slices of M bits each, and the top slice is narrower when M does not divide W. In the first compute stage every slice is added at the same moment. Only the lowest slice sees the real carry-in; the others start from zero.

A row of correction stages follows. Each stage passes one slice's carry into the next slice up. Because the slices are held in stage registers, each slice waits until its carry arrives, so the carry walks diagonally through the pipeline. The result leaves with a carry-out and a valid flag after a fixed latency of ceil(W/M)+2 cycles.

Only the valid chain has a reset. The operand and sum registers never reset, and the valid flag alone tells the user when the outputs mean something.

Top module: `chunk_ripple_adder`

## Requirements
- R1: For every accepted pair, `sum` equals (a + b + c_in) mod 2^W and `c_out` equals bit W of that full sum. This holds when W is not a multiple of M, in which case the top slice is W - M*(ceil(W/M)-1) bits wide.
- R2: `out_valid` and the matching `sum`/`c_out` appear exactly ceil(W/M)+2 clock edges after the edge that samples `in_valid` high (10 edges for W=64, M=9).
- R3: In the first compute stage, every slice above slice 0 is added with a carry-in of 0. Such a slice can therefore never show both a carry and an all-ones partial sum.
- R4: A carry created in slice 0 ripples through every higher slice. For example, all-ones plus 1 gives sum 0 and carry-out 1.
- R5: The corrected carry of slice j is the OR of the carry from the correction addition and the carry from the parallel addition. These two are never both 1.
- R6: Valid pairs on consecutive cycles give valid results on consecutive cycles, each one correct.
- R7: While `rst` is high, and on the cycle after it falls, `out_valid` is 0. Any pair in flight when reset arrives never produces `out_valid`.
- R8: A cycle with `in_valid` low produces a cycle with `out_valid` low, exactly one latency later, whatever the operand values.
- R9: All-ones plus all-ones with carry-in 1 gives sum all-ones and carry-out 1. All-ones plus zero with carry-in 1 gives sum 0 and carry-out 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset of the valid chain, active high |
| in_valid | input | 1 | Operand pair on this cycle is to be added |
| a | input | W | First operand |
| b | input | W | Second operand |
| c_in | input | 1 | Carry into bit 0 |
| out_valid | output | 1 | `sum` and `c_out` hold a result |
| sum | output | W | W-bit sum |
| c_out | output | 1 | Carry out of bit W-1 |

## Verification
The hardest case to reach from the ports is a carry that must cross every slice boundary. Random operands almost never propagate through a full 9-bit slice, let alone all of them. The stimulus therefore uses operands built to do this: all-ones against one, a lowest slice of all ones against one, and all-ones against all-ones with carry-in. These are sent back to back and mixed with idle cycles, so slices of different pairs sit next to one another in the skewed pipeline. A reset is also applied while pairs are still in flight.

// File: rtl/chunk_ripple_adder.sv
module chunk_ripple_adder #(
  parameter int W = 64,
  parameter int M = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         c_in,
  output logic         out_valid,
  output logic [W-1:0] sum,
  output logic         c_out
);

  localparam int NC  = (W + M - 1) / M;
  localparam int LAT = NC + 2;
  localparam int CNW = $clog2(LAT + 2) + 1;

  logic [W-1:0]  a_q, b_q;
  logic          ci_q, v_q;
  logic [W-1:0]  p0;
  logic [NC-1:0] c0;

  always_ff @(posedge clk) begin
    a_q  <= a;
    b_q  <= b;
    ci_q <= c_in;
  end

  always_ff @(posedge clk)
    if (rst) v_q <= 1'b0;
    else     v_q <= in_valid;

  for (genvar k = 0; k < NC; k++) begin : slc
    localparam int LO  = k * M;
    localparam int CW  = (W - LO < M) ? (W - LO) : M;
    localparam int CW1 = CW + 1;
    logic [CW:0] t;
    assign t = {1'b0, a_q[LO +: CW]} + {1'b0, b_q[LO +: CW]}
             + CW1'((k == 0) ? ci_q : 1'b0);
    assign p0[LO +: CW] = t[CW-1:0];
    assign c0[k]        = t[CW];
  end

  for (genvar j = 0; j < NC; j++) begin : stg
    logic [W-1:0]  s_r, s_n;
    logic [NC-1:0] c_r, c_n;
    logic          v_r;

    if (j == 0) begin : first
      assign s_n = p0;
      assign c_n = c0;
      always_ff @(posedge clk)
        if (rst) v_r <= 1'b0;
        else     v_r <= v_q;
    end else begin : fix
      localparam int LO  = j * M;
      localparam int CW  = (W - LO < M) ? (W - LO) : M;
      localparam int CW1 = CW + 1;
      localparam logic [W-1:0] MASK = ((W'(1) << CW) - W'(1)) << LO;
      logic [CW:0] u;
      assign u   = {1'b0, stg[j-1].s_r[LO +: CW]} + CW1'(stg[j-1].c_r[j-1]);
      assign s_n = (stg[j-1].s_r & ~MASK) | (W'(u[CW-1:0]) << LO);
      assign c_n = stg[j-1].c_r | (NC'(u[CW]) << j);
      always_ff @(posedge clk)
        if (rst) v_r <= 1'b0;
        else     v_r <= stg[j-1].v_r;

      // R5
      excl_carry_chk: assert property (@(posedge clk) disable iff (rst)
        stg[j-1].v_r |-> !(u[CW] && stg[j-1].c_r[j]));

      // R3
      raw_slice_chk: assert property (@(posedge clk) disable iff (rst)
        stg[j-1].v_r |-> !(stg[j-1].c_r[j] && (&stg[j-1].s_r[LO +: CW])));
    end

    always_ff @(posedge clk) begin
      s_r <= s_n;
      c_r <= c_n;
    end
  end

  always_ff @(posedge clk) begin
    sum   <= stg[NC-1].s_r;
    c_out <= stg[NC-1].c_r[NC-1];
  end

  always_ff @(posedge clk)
    if (rst) out_valid <= 1'b0;
    else     out_valid <= stg[NC-1].v_r;

  logic [CNW-1:0] inflight;
  always_ff @(posedge clk)
    if (rst) inflight <= '0;
    else     inflight <= inflight + CNW'(in_valid) - CNW'(out_valid);

  // R2
  inflight_bound_chk: assert property (@(posedge clk) disable iff (rst)
    inflight <= CNW'(LAT + 1));

  // R8
  no_phantom_out_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> inflight != '0);

  // R7
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !out_valid);

endmodule

// File: tb/chunk_ripple_adder_tb.sv
module chunk_ripple_adder_tb_top;
  localparam int W = 64;
  localparam int M = 9;
  localparam int LAT = (W + M - 1) / M + 2;
  localparam int CLK_PERIOD = 10;
  localparam int SZ = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic c_in = 1'b0;
  logic out_valid;
  logic [W-1:0] sum;
  logic c_out;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  logic         exp_v [SZ];
  logic [W-1:0] exp_s [SZ];
  logic         exp_c [SZ];
  string        exp_t [SZ];

  chunk_ripple_adder #(.W(W), .M(M)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .a(a), .b(b), .c_in(c_in),
    .out_valid(out_valid), .sum(sum), .c_out(c_out));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic clear_exp();
    for (int i = 0; i < SZ; i++) begin
      exp_v[i] = 1'b0;
      exp_t[i] = "R8";
    end
  endtask

  always @(negedge clk) begin
    int ix;
    ix = cyc % SZ;
    checks++;
    if (rst) begin
      if (out_valid !== 1'b0) begin
        errors++;
        $display("FAIL R7 out_valid during reset act=%b exp=0", out_valid);
      end
    end else if (out_valid !== exp_v[ix]) begin
      errors++;
      $display("FAIL %s R2 out_valid cycle %0d act=%b exp=%b",
               exp_t[ix], cyc, out_valid, exp_v[ix]);
    end else if (exp_v[ix]) begin
      checks++;
      if (sum !== exp_s[ix] || c_out !== exp_c[ix]) begin
        errors++;
        $display("FAIL %s R1 result act=%h/%b exp=%h/%b",
                 exp_t[ix], sum, c_out, exp_s[ix], exp_c[ix]);
      end
    end
    exp_v[ix] = 1'b0;
    exp_t[ix] = "R8";
  end

  task automatic push(input logic [W-1:0] x, input logic [W-1:0] y,
                      input logic ci, input string tag);
    logic [W:0] r;
    int ix;
    @(negedge clk);
    a = x; b = y; c_in = ci; in_valid = 1'b1;
    r = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
    ix = (cyc + LAT) % SZ;
    exp_v[ix] = 1'b1;
    exp_s[ix] = r[W-1:0];
    exp_c[ix] = r[W];
    exp_t[ix] = tag;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      a = {$urandom, $urandom}; b = {$urandom, $urandom}; c_in = 1'($urandom);
    end
  endtask

  task automatic drain();
    idle(LAT + 2);
  endtask

  task automatic do_reset(input int n);
    @(negedge clk);
    #1;
    rst = 1'b1;
    in_valid = 1'b0;
    clear_exp();
    repeat (n) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(4);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R7 out_valid after reset act=%b exp=0", out_valid);
    end
  endtask

  task automatic t_random();
    for (int i = 0; i < 24; i++)
      push({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R6");
    drain();
  endtask

  task automatic t_ripple();
    push({W{1'b1}}, W'(1), 1'b0, "R4");
    push({W{1'b1}}, '0, 1'b1, "R4");
    push({1'b0, {(W-1){1'b1}}}, W'(1), 1'b0, "R4");
    push(W'((1 << M) - 1), W'(1), 1'b0, "R3");
    push(W'((1 << M) - 1), '0, 1'b1, "R3");
    push({W{1'b1}} ^ W'(1 << M), W'(1 << M), 1'b1, "R5");
    drain();
  endtask

  task automatic t_allones();
    push({W{1'b1}}, {W{1'b1}}, 1'b1, "R9");
    push({W{1'b1}}, '0, 1'b1, "R9");
    push({W{1'b1}}, {W{1'b1}}, 1'b0, "R9");
    drain();
  endtask

  task automatic t_bubble();
    for (int i = 0; i < 12; i++) begin
      push({$urandom, $urandom}, {W{1'b1}}, 1'($urandom), "R8");
      idle(1 + i % 3);
    end
    drain();
  endtask

  task automatic t_midreset();
    for (int i = 0; i < 6; i++)
      push({W{1'b1}}, W'(i), 1'b1, "R7");
    do_reset(2);
    drain();
    push({$urandom, $urandom}, {$urandom, $urandom}, 1'b0, "R7");
    drain();
  endtask

  initial begin
    clear_exp();
    t_reset();
    t_random();
    t_ripple();
    t_allones();
    t_bubble();
    t_midreset();
    t_random();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule